// File: doc/BRIEF.md
# Key-Locked System Control Register

This block is a single 32-bit control word in an interrupt controller's system control space. Software can change it only by supplying a 16-bit unlock value in the upper half of the same write. The word holds a byte-order flag and a 3-bit priority-grouping code. The grouping code decides how an 8-bit exception priority is divided between a pre-emption part and a subpriority part, and the block outputs that division directly for any priority presented to it.

The low bits of the word act as commands rather than storage. One bit sends a single-cycle pulse that wipes all active exception state. A second bit sends a single-cycle local system reset pulse. A third bit sets a system-reset request that stays high until a warm reset arrives. Reading the word returns a fixed signature in place of the key, with all reserved bits at zero. Any write without the key is discarded as a whole and raises a one-cycle key-error flag.

Top module: `sysctl_keyreg`

## Requirements
- R1: A write (`wr_en`=1) is accepted only when `wr_data[31:16]` equals 16'h05FA and both `wr_strb[3]` and `wr_strb[2]` are 1. Any other write changes no state and drives `key_err` high for exactly the cycle after it. An accepted write leaves `key_err` low.
- R2: `rd_data[31:16]` always reads 16'hFA05.
- R3: Bit 15 is the byte-order flag (1 = big endian). An accepted write with `wr_strb[1]`=1 loads it from `wr_data[15]`. It is visible on `big_endian` and on `rd_data[15]` from the cycle after the write.
- R4: `rd_data[14:11]`, `rd_data[7:3]`, `rd_data[1]` and `rd_data[0]` always read 0.
- R5: Bits 10:8 are the grouping code g. An accepted write with `wr_strb[1]`=1 loads g, and from the next cycle it appears on `pri_group` and on `rd_data[10:8]`.
- R6: With grouping code g, `sub_out` = `pri_in` masked to its low g+1 bits, and `pre_out` = `pri_in` with those bits cleared. When g=7, `pre_out` is 0 and `sub_out` equals `pri_in`.
- R7: An accepted write with `wr_strb[0]`=1 and `wr_data[1]`=1 drives `clr_active` high for exactly the following cycle.
- R8: An accepted write with `wr_strb[0]`=1 and `wr_data[0]`=1 drives `local_reset` high for exactly the following cycle.
- R9: An accepted write with `wr_strb[0]`=1 and `wr_data[2]`=1 sets `sysreset_req` from the next cycle, and `rd_data[2]` reads the same value. A later write of 0 to bit 2 leaves it set.
- R10: `warm_rst` clears `sysreset_req`, `clr_active` and `local_reset` on the following cycle, and it overrides command bits written in the same cycle. It leaves the byte-order flag and the grouping code unchanged.
- R11: When `rst` is high at a clock edge, every stored field and every output flag is 0 after that edge.
- R12: In an accepted write, bits 2:0 are ignored when `wr_strb[0]`=0, and bits 15 and 10:8 are ignored when `wr_strb[1]`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous warm reset for the command state |
| wr_en | input | 1 | Write request |
| wr_strb | input | 4 | Byte-lane write strobes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data |
| pri_in | input | 8 | Priority value to divide |
| pri_group | output | 3 | Current grouping code |
| pre_out | output | 8 | Pre-emption part of pri_in, other bits zero |
| sub_out | output | 8 | Subpriority part of pri_in, other bits zero |
| big_endian | output | 1 | Byte-order flag |
| clr_active | output | 1 | One-cycle clear-active-state pulse |
| local_reset | output | 1 | One-cycle local system reset pulse |
| sysreset_req | output | 1 | Latched system-reset request |
| key_err | output | 1 | One-cycle flag for a rejected write |

## Verification
The case hardest to reach from the ports is a warm reset that lands in the same cycle as an accepted command write. Here the priority rule decides the outcome, and the configuration written in that cycle must still take effect. The stimulus builds that collision on purpose. It also sends writes that carry the correct key value but lack an upper strobe, and writes with only one low lane enabled. The reference model is compared on every cycle, so a pulse that lasts one cycle too long shows up directly.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DATA_W = 32;
    localparam int PRI_W  = 8;
    localparam int GRP_W  = $clog2(PRI_W);
    localparam logic [15:0] UNLOCK_KEY = 16'h05FA;
    localparam logic [15:0] READ_SIG   = 16'hFA05;

    // field positions within the control word
    localparam int BIT_ENDIAN = 15;
    localparam int GRP_LSB    = 8;
    localparam int BIT_SYSREQ = 2;
    localparam int BIT_CLRACT = 1;
    localparam int BIT_LOCRST = 0;

    typedef struct packed {
        logic             big_endian;
        logic [GRP_W-1:0] group;
    } cfg_t;

    typedef struct packed {
        logic sysreq;
        logic clr_active;
        logic local_reset;
    } cmd_t;

    typedef struct packed {
        logic accept;
        logic reject;
        logic cfg_lane;
        logic cmd_lane;
    } wdec_t;

    // low (g+1) bits set: the subpriority part
    function automatic logic [PRI_W-1:0] sub_mask(input logic [GRP_W-1:0] g);
        logic [PRI_W-1:0] m;
        for (int i = 0; i < PRI_W; i++) begin
            m[i] = (i <= int'(g));
        end
        return m;
    endfunction
endpackage

// File: rtl/sysctl_keygate.sv
module sysctl_keygate
    import sysctl_pkg::*;
(
    input  logic              wr_en,
    input  logic [3:0]        wr_strb,
    input  logic [DATA_W-1:0] wr_data,
    output wdec_t             dec
);
    logic key_ok;

    always_comb begin
        key_ok       = (wr_data[DATA_W-1:16] == UNLOCK_KEY) && wr_strb[3] && wr_strb[2];
        dec.accept   = wr_en && key_ok;
        dec.reject   = wr_en && !key_ok;
        dec.cfg_lane = dec.accept && wr_strb[1];
        dec.cmd_lane = dec.accept && wr_strb[0];
    end
endmodule

// File: rtl/sysctl_cfgreg.sv
module sysctl_cfgreg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wdec_t             dec,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (dec.cfg_lane) begin
            cfg.big_endian <= wr_data[BIT_ENDIAN];
            cfg.group      <= wr_data[GRP_LSB +: GRP_W];
        end
    end
endmodule

// File: rtl/sysctl_cmdreg.sv
module sysctl_cmdreg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  wdec_t             dec,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_t              cmd,
    output logic              key_err
);
    cmd_t nxt;

    always_comb begin
        nxt.clr_active  = dec.cmd_lane && wr_data[BIT_CLRACT];
        nxt.local_reset = dec.cmd_lane && wr_data[BIT_LOCRST];
        nxt.sysreq      = cmd.sysreq || (dec.cmd_lane && wr_data[BIT_SYSREQ]);
        if (warm_rst) begin
            nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd     <= '0;
            key_err <= 1'b0;
        end else begin
            cmd     <= nxt;
            key_err <= dec.reject;
        end
    end
endmodule

// File: rtl/sysctl_prisplit.sv
module sysctl_prisplit
    import sysctl_pkg::*;
(
    input  logic [PRI_W-1:0] pri_in,
    input  logic [GRP_W-1:0] group,
    output logic [PRI_W-1:0] pre_out,
    output logic [PRI_W-1:0] sub_out
);
    logic [PRI_W-1:0] mask;

    always_comb begin
        mask    = sub_mask(group);
        sub_out = pri_in & mask;
        pre_out = pri_in & ~mask;
    end
endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_strb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PRI_W-1:0]  pri_in,
    output logic [GRP_W-1:0]  pri_group,
    output logic [PRI_W-1:0]  pre_out,
    output logic [PRI_W-1:0]  sub_out,
    output logic              big_endian,
    output logic              clr_active,
    output logic              local_reset,
    output logic              sysreset_req,
    output logic              key_err
);
    wdec_t dec;
    cfg_t  cfg;
    cmd_t  cmd;

    sysctl_keygate u_gate (
        .wr_en   (wr_en),
        .wr_strb (wr_strb),
        .wr_data (wr_data),
        .dec     (dec)
    );

    sysctl_cfgreg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    sysctl_cmdreg u_cmd (
        .clk      (clk),
        .rst      (rst),
        .warm_rst (warm_rst),
        .dec      (dec),
        .wr_data  (wr_data),
        .cmd      (cmd),
        .key_err  (key_err)
    );

    sysctl_prisplit u_split (
        .pri_in  (pri_in),
        .group   (cfg.group),
        .pre_out (pre_out),
        .sub_out (sub_out)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[DATA_W-1:16]         = READ_SIG;
        rd_data[BIT_ENDIAN]          = cfg.big_endian;
        rd_data[GRP_LSB +: GRP_W]    = cfg.group;
        rd_data[BIT_SYSREQ]          = cmd.sysreq;
    end

    assign pri_group    = cfg.group;
    assign big_endian   = cfg.big_endian;
    assign clr_active   = cmd.clr_active;
    assign local_reset  = cmd.local_reset;
    assign sysreset_req = cmd.sysreq;
endmodule

// File: rtl/sysctl_keyreg_chk.sv
module sysctl_keyreg_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              warm_rst,
    input logic              wr_en,
    input logic [3:0]        wr_strb,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [PRI_W-1:0]  pri_in,
    input logic [GRP_W-1:0]  pri_group,
    input logic [PRI_W-1:0]  pre_out,
    input logic [PRI_W-1:0]  sub_out,
    input logic              big_endian,
    input logic              clr_active,
    input logic              local_reset,
    input logic              sysreset_req,
    input logic              key_err
);
    p_key_err_r1: assert property (@(posedge clk) disable iff (rst)
        key_err |-> ($past(wr_en) &&
                     !($past(wr_data[31:16]) == UNLOCK_KEY && $past(wr_strb[3]) && $past(wr_strb[2]))));

    p_signature_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:16] == READ_SIG);

    p_reserved_r4: assert property (@(posedge clk) disable iff (rst)
        rd_data[14:11] == 4'd0 && rd_data[7:3] == 5'd0 && rd_data[1:0] == 2'd0);

    p_split_r6: assert property (@(posedge clk) disable iff (rst)
        ((pre_out & sub_out) == '0) && ((pre_out | sub_out) == pri_in) && sub_out[0] == pri_in[0]);

    p_clr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        clr_active |-> ($past(wr_en) && $past(wr_data[1]) && $past(wr_strb[0]) && !$past(warm_rst)));

    p_locrst_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        local_reset |-> ($past(wr_en) && $past(wr_data[0]) && $past(wr_strb[0]) && !$past(warm_rst)));

    p_sysreq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (sysreset_req && !warm_rst) |=> sysreset_req);

    p_warm_clear_r10: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> (!sysreset_req && !clr_active && !local_reset));

    p_cfg_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(big_endian) && $stable(pri_group)));
endmodule

bind sysctl_keyreg sysctl_keyreg_chk u_chk (.*);

// File: tb/sysctl_keyreg_bench.sv
`timescale 1ns/1ps
module sysctl_keyreg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic [7:0]  pri_in = 8'h00;
    logic [2:0]  pri_group;
    logic [7:0]  pre_out, sub_out;
    logic        big_endian, clr_active, local_reset, sysreset_req, key_err;

    int errors = 0;
    int checks = 0;
    string phase = "R11 reset";

    // reference state
    bit       m_end, m_req, m_clr, m_lrst, m_kerr;
    bit [2:0] m_grp;

    always #2.5 clk = ~clk;

    sysctl_keyreg u_sysctl_keyreg (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .wr_strb(wr_strb),
        .wr_data(wr_data), .rd_data(rd_data), .pri_in(pri_in), .pri_group(pri_group),
        .pre_out(pre_out), .sub_out(sub_out), .big_endian(big_endian),
        .clr_active(clr_active), .local_reset(local_reset),
        .sysreset_req(sysreset_req), .key_err(key_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
        end
    endtask

    // apply the edge that just happened to the reference model
    task automatic model_edge();
        bit acc;
        if (rst) begin
            m_end = 0; m_grp = 0; m_req = 0; m_clr = 0; m_lrst = 0; m_kerr = 0;
        end else begin
            acc    = wr_en && wr_data[31:16] == 16'h05FA && wr_strb[3] && wr_strb[2];
            m_kerr = wr_en && !acc;
            if (acc && wr_strb[1]) begin
                m_end = wr_data[15];
                m_grp = wr_data[10:8];
            end
            m_clr  = !warm_rst && acc && wr_strb[0] && wr_data[1];
            m_lrst = !warm_rst && acc && wr_strb[0] && wr_data[0];
            if (warm_rst) m_req = 0;
            else if (acc && wr_strb[0] && wr_data[2]) m_req = 1;
        end
    endtask

    task automatic compare();
        logic [7:0] ms, mp;
        logic [31:0] rexp;
        for (int i = 0; i < 8; i++) begin
            ms[i] = (i <= int'(m_grp)) ? pri_in[i] : 1'b0;
            mp[i] = (i <= int'(m_grp)) ? 1'b0 : pri_in[i];
        end
        rexp = {16'hFA05, m_end, 4'b0, m_grp, 5'b0, m_req, 2'b0};
        chk("R2 signature", {16'h0, rd_data[31:16]}, 32'h0000FA05);
        chk("R4 reserved", {rd_data[14:11], rd_data[7:3], rd_data[1:0]}, 32'h0);
        chk("R3 endian", {31'h0, big_endian}, {31'h0, m_end});
        chk("R5 group", {29'h0, pri_group}, {29'h0, m_grp});
        chk("R6 pre", {24'h0, pre_out}, {24'h0, mp});
        chk("R6 sub", {24'h0, sub_out}, {24'h0, ms});
        chk("R7 clr_active", {31'h0, clr_active}, {31'h0, m_clr});
        chk("R8 local_reset", {31'h0, local_reset}, {31'h0, m_lrst});
        chk("R9 sysreset_req", {31'h0, sysreset_req}, {31'h0, m_req});
        chk("R1 key_err", {31'h0, key_err}, {31'h0, m_kerr});
        chk("R3 R5 R9 rd_data", rd_data, rexp);
    endtask

    // hold the inputs over one edge, then check at the falling edge
    task automatic cyc(input bit w, input logic [3:0] s, input logic [31:0] d,
                       input logic [7:0] p, input bit wr_warm);
        wr_en = w; wr_strb = s; wr_data = d; pri_in = p; warm_rst = wr_warm;
        @(negedge clk);
        model_edge();
        compare();
    endtask

    task automatic idle(input logic [7:0] p);
        cyc(0, 4'h0, 32'h0, p, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        phase = "R11 reset";
        rst = 1;
        cyc(1, 4'hF, 32'h05FA_8707, 8'hA5, 0);
        cyc(0, 4'h0, 32'h0, 8'h3C, 0);
        rst = 0;
        idle(8'hFF);

        phase = "R3 R5 accepted config";
        cyc(1, 4'hF, 32'h05FA_8300, 8'hB7, 0);
        idle(8'hB7);

        phase = "R1 bad key";
        cyc(1, 4'hF, 32'h05FB_0207, 8'h5A, 0);
        cyc(1, 4'hF, 32'hFA05_0006, 8'h5A, 0);
        phase = "R1 missing upper strobe";
        cyc(1, 4'h7, 32'h05FA_0007, 8'h81, 0);
        cyc(1, 4'hB, 32'h05FA_0007, 8'h81, 0);
        idle(8'h81);

        phase = "R7 clear pulse";
        cyc(1, 4'hD, 32'h05FA_0002, 8'h11, 0);
        idle(8'h11);
        idle(8'h11);
        phase = "R8 local reset pulse";
        cyc(1, 4'hD, 32'h05FA_0001, 8'h22, 0);
        cyc(1, 4'hD, 32'h05FA_0001, 8'h22, 0);
        idle(8'h22);

        phase = "R9 request latch";
        cyc(1, 4'hD, 32'h05FA_0004, 8'h44, 0);
        idle(8'h44);
        cyc(1, 4'hF, 32'h05FA_0500, 8'h44, 0);
        idle(8'h44);

        phase = "R12 lane masking";
        cyc(1, 4'hE, 32'h05FA_0003, 8'h99, 0);
        cyc(1, 4'hD, 32'h05FA_0000, 8'h99, 0);
        idle(8'h99);

        phase = "R6 group sweep";
        for (int g = 0; g < 8; g++) begin
            cyc(1, 4'hE, {16'h05FA, 1'b1, 4'b0, 3'(g), 8'h00}, 8'hFF, 0);
            idle(8'hC3);
            idle(8'h5A);
        end

        phase = "R10 warm reset";
        cyc(1, 4'hF, 32'h05FA_0200, 8'h0F, 1);
        idle(8'h0F);
        cyc(1, 4'hD, 32'h05FA_0004, 8'h0F, 0);
        cyc(1, 4'hF, 32'h05FA_8607, 8'h0F, 1);
        idle(8'h0F);
        cyc(1, 4'hD, 32'h05FA_0007, 8'h0F, 0);
        cyc(0, 4'h0, 32'h0, 8'h0F, 1);
        idle(8'h0F);

        phase = "R11 cold reset";
        cyc(1, 4'hD, 32'h05FA_0007, 8'hE1, 0);
        rst = 1;
        idle(8'hE1);
        rst = 0;
        idle(8'hE1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule